// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block sits in an instruction decoder of a 16-bit processor. It takes an addressing-mode byte from an instruction byte stream, pulls in the zero, one or two displacement bytes the mode calls for, and produces a 16-bit effective address together with the segment register that qualifies it. When the mode byte names a register rather than memory, the block reports the register number and no address.

The mode byte is split as mode (bits 7:6), a middle field that the block ignores (bits 5:3) and a register/memory selector (bits 2:0). The base registers, the segment override and the string-destination flag come from the surrounding core. The block holds off further bytes while it finishes an address, and it signals each result with a one-cycle done pulse. Forming the physical address, reading the operand and holding the register file are left to other blocks.

Top module: `ea_gen`

## Requirements
- R1: After reset `out_done` and `out_is_reg` are 0, `out_ea` is 0, `out_seg` is 2'b11, `out_reg` is 0 and `in_ready` is 1.
- R2: A mode byte with mode 2'b11 consumes no displacement bytes; the result has `out_is_reg` = 1, `out_reg` = bits 2:0 of the mode byte and `out_ea` = 0.
- R3: Mode 2'b00 takes no displacement (except per R5), mode 2'b01 takes one byte sign-extended to 16 bits, mode 2'b10 takes two bytes with the low byte first.
- R4: For selector values 0..7 the base is BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX, and the displacement is added to it.
- R5: Mode 2'b00 with selector 3'b110 takes two displacement bytes (low first) and the address is that displacement alone; no register is added and the default segment is DS.
- R6: Segment codes are ES=2'b00, CS=2'b01, SS=2'b10, DS=2'b11. An address whose base includes BP defaults to SS; every other address defaults to DS.
- R7: When `ovr_valid` is 1, `ovr_seg` replaces the default segment.
- R8: When `str_dst` is 1 the segment is ES, whatever the override says.
- R9: The sum of base registers and displacement wraps modulo 2^16.
- R10: `out_done` rises at the clock edge after the edge that accepts the last byte of a sequence, stays high for exactly one cycle, and the outputs change only at that edge; BX, BP, SI, DI, `ovr_valid`, `ovr_seg` and `str_dst` are sampled at that same edge.
- R11: `in_ready` is 0 in the cycle between acceptance of the last byte and `out_done`, is 1 in the cycle `out_done` is high (so the next mode byte can be taken then), and gaps in `in_valid` between bytes have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte (mode byte or displacement) |
| in_ready | output | 1 | Block accepts a byte this cycle |
| reg_bx | input | AW | Current BX value |
| reg_bp | input | AW | Current BP value |
| reg_si | input | AW | Current SI value |
| reg_di | input | AW | Current DI value |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| str_dst | input | 1 | Operand is a string destination |
| out_done | output | 1 | One-cycle result pulse |
| out_ea | output | AW | Effective address |
| out_seg | output | 2 | Selected segment code |
| out_is_reg | output | 1 | Operand is a register |
| out_reg | output | 3 | Register number when out_is_reg |

## Verification
The completion of one address and the acceptance of the next mode byte fall in the same cycle: the cycle in which `out_done` is high also has `in_ready` high. The bench provokes this by holding `in_valid` high with the next mode byte already presented while the first result is being computed. It judges that the first result is correct in the done cycle, that the new byte is taken there, and that the second result, which consumes a sign-extended displacement, is also correct one sequence later.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'b00,
    SEG_CS = 2'b01,
    SEG_SS = 2'b10,
    SEG_DS = 2'b11
  } seg_e;

  typedef enum logic [1:0] {
    MD_NODISP = 2'b00,
    MD_DISP8  = 2'b01,
    MD_DISP16 = 2'b10,
    MD_REG    = 2'b11
  } mod_e;

  localparam logic [2:0] RM_DIRECT = 3'b110;
endpackage

// File: rtl/ea_fetch.sv
module ea_fetch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          go,
  output logic [1:0]    mod_q,
  output logic [2:0]    rm_q,
  output logic [AW-1:0] disp_q
);
  import ea_pkg::*;

  localparam int EXT = AW - 8;

  typedef enum logic [1:0] {F_MODE, F_LO, F_HI, F_CALC} fst_e;
  fst_e st;

  logic take;
  logic needs_disp;
  assign take     = in_valid && in_ready;
  assign in_ready = (st != F_CALC);
  assign go       = (st == F_CALC);

  // displacement is needed for 8/16-bit modes and the direct-address case
  assign needs_disp = (in_data[7:6] == MD_DISP8) || (in_data[7:6] == MD_DISP16) ||
                      ((in_data[7:6] == MD_NODISP) && (in_data[2:0] == RM_DIRECT));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= F_MODE;
      mod_q  <= 2'b00;
      rm_q   <= 3'b000;
      disp_q <= '0;
    end else begin
      case (st)
        F_MODE: if (take) begin
          mod_q  <= in_data[7:6];
          rm_q   <= in_data[2:0];
          disp_q <= '0;
          st     <= needs_disp ? F_LO : F_CALC;
        end
        F_LO: if (take) begin
          if (mod_q == MD_DISP8) begin
            disp_q <= {{EXT{in_data[7]}}, in_data};
            st     <= F_CALC;
          end else begin
            disp_q[7:0] <= in_data;
            st          <= F_HI;
          end
        end
        F_HI: if (take) begin
          disp_q[15:8] <= in_data;
          st           <= F_CALC;
        end
        default: st <= F_MODE;
      endcase
    end
  end
endmodule

// File: rtl/ea_base.sv
module ea_base #(
  parameter int AW = 16
) (
  input  logic [1:0]    mod_i,
  input  logic [2:0]    rm_i,
  input  logic [AW-1:0] bx,
  input  logic [AW-1:0] bp,
  input  logic [AW-1:0] si,
  input  logic [AW-1:0] di,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] ea,
  output logic          via_bp
);
  import ea_pkg::*;

  logic [AW-1:0] b1, b2;

  always_comb begin
    b1     = '0;
    b2     = '0;
    via_bp = 1'b0;
    case (rm_i)
      3'b000: begin b1 = bx; b2 = si; end
      3'b001: begin b1 = bx; b2 = di; end
      3'b010: begin b1 = bp; b2 = si; via_bp = 1'b1; end
      3'b011: begin b1 = bp; b2 = di; via_bp = 1'b1; end
      3'b100: b1 = si;
      3'b101: b1 = di;
      3'b110: if (mod_i != MD_NODISP) begin b1 = bp; via_bp = 1'b1; end
      default: b1 = bx;
    endcase
  end

  // natural truncation gives the modulo-2^AW wrap
  assign ea = b1 + b2 + disp;
endmodule

// File: rtl/ea_segsel.sv
module ea_segsel (
  input  logic           via_bp,
  input  logic           ovr_valid,
  input  logic [1:0]     ovr_seg,
  input  logic           str_dst,
  output ea_pkg::seg_e   seg
);
  import ea_pkg::*;

  always_comb begin
    if (str_dst)        seg = SEG_ES;
    else if (ovr_valid) seg = seg_e'(ovr_seg);
    else if (via_bp)    seg = SEG_SS;
    else                seg = SEG_DS;
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic [AW-1:0] reg_bx,
  input  logic [AW-1:0] reg_bp,
  input  logic [AW-1:0] reg_si,
  input  logic [AW-1:0] reg_di,
  input  logic          ovr_valid,
  input  logic [1:0]    ovr_seg,
  input  logic          str_dst,
  output logic          out_done,
  output logic [AW-1:0] out_ea,
  output logic [1:0]    out_seg,
  output logic          out_is_reg,
  output logic [2:0]    out_reg
);
  import ea_pkg::*;

  logic          go;
  logic [1:0]    mod_q;
  logic [2:0]    rm_q;
  logic [AW-1:0] disp_q;
  logic [AW-1:0] sum;
  logic          via_bp;
  seg_e          seg_sel;

  ea_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .go(go), .mod_q(mod_q), .rm_q(rm_q), .disp_q(disp_q)
  );

  ea_base #(.AW(AW)) u_base (
    .mod_i(mod_q), .rm_i(rm_q), .bx(reg_bx), .bp(reg_bp), .si(reg_si),
    .di(reg_di), .disp(disp_q), .ea(sum), .via_bp(via_bp)
  );

  ea_segsel u_seg (
    .via_bp(via_bp), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .str_dst(str_dst), .seg(seg_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done   <= 1'b0;
      out_ea     <= '0;
      out_seg    <= SEG_DS;
      out_is_reg <= 1'b0;
      out_reg    <= 3'b000;
    end else begin
      out_done <= go;
      if (go) begin
        out_is_reg <= (mod_q == MD_REG);
        out_reg    <= rm_q;
        out_ea     <= (mod_q == MD_REG) ? '0 : sum;
        out_seg    <= seg_sel;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [7:0]    in_data,
  input logic          in_ready,
  input logic [AW-1:0] reg_bx,
  input logic [AW-1:0] reg_bp,
  input logic [AW-1:0] reg_si,
  input logic [AW-1:0] reg_di,
  input logic          ovr_valid,
  input logic [1:0]    ovr_seg,
  input logic          str_dst,
  input logic          out_done,
  input logic [AW-1:0] out_ea,
  input logic [1:0]    out_seg,
  input logic          out_is_reg,
  input logic [2:0]    out_reg
);
  // R2: register operand carries no address
  a_r2_reg_no_addr: assert property (@(posedge clk) disable iff (rst)
    out_done && out_is_reg |-> out_ea == '0);

  // R8: string destination wins over everything
  a_r8_string_es: assert property (@(posedge clk) disable iff (rst)
    out_done && $past(str_dst) |-> out_seg == 2'b00);

  // R7: override replaces default
  a_r7_override: assert property (@(posedge clk) disable iff (rst)
    out_done && !out_is_reg && $past(ovr_valid) && !$past(str_dst)
      |-> out_seg == $past(ovr_seg));

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);

  // R10: address output moves only together with done
  a_r10_ea_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_ea) |-> out_done);

  // R11: ready is back in the done cycle
  a_r11_ready_on_done: assert property (@(posedge clk) disable iff (rst)
    out_done |-> in_ready);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_ea_gen.sv
module sim_ea_gen;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready;
  logic [AW-1:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic          ovr_valid = 1'b0;
  logic [1:0]    ovr_seg = 2'b00;
  logic          str_dst = 1'b0;
  logic          out_done;
  logic [AW-1:0] out_ea;
  logic [1:0]    out_seg;
  logic          out_is_reg;
  logic [2:0]    out_reg;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ea_gen #(.AW(AW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ea(input logic [7:0] mb, input logic [15:0] d);
    logic [15:0] b;
    case (mb[2:0])
      3'd0: b = reg_bx + reg_si;
      3'd1: b = reg_bx + reg_di;
      3'd2: b = reg_bp + reg_si;
      3'd3: b = reg_bp + reg_di;
      3'd4: b = reg_si;
      3'd5: b = reg_di;
      3'd6: b = (mb[7:6] == 2'b00) ? 16'h0000 : reg_bp;
      default: b = reg_bx;
    endcase
    return (mb[7:6] == 2'b11) ? 16'h0000 : 16'(b + d);
  endfunction

  function automatic logic [1:0] exp_seg(input logic [7:0] mb);
    logic bpb;
    bpb = (mb[2:1] == 2'b01) || (mb[2:0] == 3'b110 && mb[7:6] != 2'b00);
    if (str_dst) return 2'b00;
    if (ovr_valid) return ovr_seg;
    return bpb ? 2'b10 : 2'b11;
  endfunction

  // called at a negedge; returns at the negedge after acceptance
  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic [7:0] mb, input int nd,
                        input logic [7:0] d0, input logic [7:0] d1, input int gap);
    logic [15:0] d;
    d = (nd == 1) ? {{8{d0[7]}}, d0} : (nd == 2) ? {d1, d0} : 16'h0000;
    send_byte(mb, 0);
    if (nd >= 1) send_byte(d0, gap);
    if (nd == 2) send_byte(d1, gap);
    chk({req, " R11 ready low"}, in_ready, 0);
    chk({req, " R10 not yet done"}, out_done, 0);
    @(negedge clk);
    chk({req, " R10 done"}, out_done, 1);
    chk({req, " ea"}, out_ea, exp_ea(mb, d));
    chk({req, " is_reg"}, out_is_reg, (mb[7:6] == 2'b11));
    if (mb[7:6] == 2'b11) chk({req, " reg"}, out_reg, mb[2:0]);
    else chk({req, " seg"}, out_seg, exp_seg(mb));
    @(negedge clk);
    chk({req, " R10 done pulse ends"}, out_done, 0);
  endtask

  task automatic t_reset;
    chk("R1 done", out_done, 0);
    chk("R1 ea", out_ea, 0);
    chk("R1 seg", out_seg, 2'b11);
    chk("R1 is_reg", out_is_reg, 0);
    chk("R1 reg", out_reg, 0);
    chk("R1 ready", in_ready, 1);
  endtask

  task automatic t_register;
    run_op("R2", 8'b11_010_101, 0, 8'h00, 8'h00, 0);
    run_op("R2", 8'b11_111_000, 0, 8'h00, 8'h00, 0);
  endtask

  task automatic t_bases;
    reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0004;
    for (int r = 0; r < 8; r++)
      if (r != 6) run_op("R4 R6 mod0", {2'b00, 3'b000, 3'(r)}, 0, 8'h00, 8'h00, 0);
    for (int r = 0; r < 8; r++)
      run_op("R4 R6 mod2", {2'b10, 3'b000, 3'(r)}, 2, 8'h21, 8'h03, 0);
  endtask

  task automatic t_disp8;
    run_op("R3 neg", 8'b01_000_111, 1, 8'h80, 8'h00, 0);
    run_op("R3 pos", 8'b01_000_110, 1, 8'h7F, 8'h00, 0);
  endtask

  task automatic t_direct;
    run_op("R5", 8'b00_000_110, 2, 8'h34, 8'h12, 0);
  endtask

  task automatic t_wrap;
    reg_bx = 16'hFFF0; reg_si = 16'h0020;
    run_op("R9", 8'b10_000_000, 2, 8'h00, 8'h01, 0);
  endtask

  task automatic t_override;
    ovr_valid = 1'b1; ovr_seg = 2'b01;
    run_op("R7 bp", 8'b01_000_110, 1, 8'h10, 8'h00, 0);
    ovr_seg = 2'b00;
    run_op("R7 bx", 8'b00_000_111, 0, 8'h00, 8'h00, 0);
    ovr_valid = 1'b0;
  endtask

  task automatic t_string;
    str_dst = 1'b1; ovr_valid = 1'b1; ovr_seg = 2'b10;
    run_op("R8", 8'b00_000_101, 0, 8'h00, 8'h00, 0);
    ovr_valid = 1'b0;
    run_op("R8 no ovr", 8'b00_000_010, 0, 8'h00, 8'h00, 0);
    str_dst = 1'b0;
  endtask

  task automatic t_stall;
    reg_bp = 16'h0500; reg_di = 16'h0006;
    run_op("R11 gaps", 8'b10_000_011, 2, 8'hFE, 8'h7F, 3);
  endtask

  // R11: the done cycle also takes the next mode byte
  task automatic t_b2b;
    reg_si = 16'h0100;
    in_valid = 1'b1; in_data = 8'b11_000_011;
    @(posedge clk); @(negedge clk);
    in_data = 8'b01_000_100;
    chk("R11 b2b calc ready", in_ready, 0);
    chk("R11 b2b calc done", out_done, 0);
    @(negedge clk);
    chk("R11 b2b done1", out_done, 1);
    chk("R11 b2b ready on done", in_ready, 1);
    chk("R2 b2b is_reg", out_is_reg, 1);
    chk("R2 b2b reg", out_reg, 3);
    @(posedge clk); @(negedge clk);
    in_data = 8'hFB;
    chk("R11 b2b disp ready", in_ready, 1);
    chk("R10 b2b pulse over", out_done, 0);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11 b2b done2", out_done, 1);
    chk("R3 b2b ea", out_ea, 16'h00FB);
    chk("R6 b2b seg", out_seg, 2'b11);
    chk("R2 b2b mem", out_is_reg, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_register();
    t_bases();
    t_disp8();
    t_direct();
    t_wrap();
    t_override();
    t_string();
    t_stall();
    t_b2b();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule